// File: doc/BRIEF.md
# Strided Interleaved Vector Load Unit

This block fetches one vector from a memory made of several low-order interleaved banks. A start command supplies a base word address, a stride and an element count. The block produces the address of every element, sends at most one request per cycle to the bank that holds that address, and writes the returned words to a vector register write port. Each write is tagged with its element index. When the last element has been written, the block pulses `done`. The `cycles` output then holds the length of the whole load.

A bank that accepts a request stays busy for `BUSY` cycles. Requests leave in strict element order. If the bank of the next element is still busy, issue stalls until that bank is free. The load time therefore depends on the stride. When the stride shares no factor with the bank count, the load streams at one element per cycle. When the stride is a multiple of the bank count, every access lands on one bank and the load serialises onto it. Read data returns a fixed latency after the request; that latency is a property of the memory, not of this block.

The control is a four-state machine:
- `ST_IDLE` waits for `start`. On start it goes to `ST_ISSUE`, or to `ST_DONE` when the clamped length is zero.
- `ST_ISSUE` sends one request in each cycle where the target bank is free. It moves to `ST_DRAIN` on the cycle that sends the last element.
- `ST_DRAIN` collects the remaining returns. It moves to `ST_DONE` on the cycle that writes the last element.
- `ST_DONE` lasts one cycle and returns to `ST_IDLE`.

Top module: `vld_strided_load`

## Requirements
- R1: After reset, `mem_req`, `wr_en` and `done` are 0 and `cycles` is 0.
- R2: Element i is requested at address (base + i*stride) mod 2^AW. Requests leave in ascending element order, at most one per cycle, and address arithmetic wraps at 2^AW.
- R3: The bank of an address is its low log2(NB) bits. No bank receives a new request within BUSY cycles of its previous one.
- R4: No stall happens while the next element's bank is free. Stride 1 issues all elements on consecutive cycles, starting in the cycle after `start`.
- R5: Returned words are written in ascending element index 0..n-1. `wr_idx` carries the index and `wr_data` carries the returned word unchanged.
- R6: `cycles` counts from the cycle after `start` through the cycle of the last write. With NB=8, BUSY=6 and a 12-cycle memory latency, a 64-element stride-1 load reads 76.
- R7: A 64-element load whose stride is a multiple of NB (for example 32) hits one bank and reads 391.
- R8: Partially shared strides give intermediate timing with 64 elements: stride 9 reads 76, stride 2 reads 106, stride 4 reads 200, and stride 0 with 3 elements reads 25.
- R9: A length of 0 pulses `done` in the cycle after `start`, sends no request, writes nothing, and leaves `cycles` at 0.
- R10: `done` is high for exactly one cycle, in the cycle after the last write. `cycles` keeps its value until the next start.
- R11: A length above MAXVL (64) is treated as MAXVL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a load; sampled only in ST_IDLE |
| base | input | AW | Word address of element 0 |
| stride | input | AW | Address step between elements, in words |
| vlen | input | LW | Element count, clamped to MAXVL |
| mem_req | output | 1 | Request to the bank selected by mem_addr |
| mem_addr | output | AW | Word address of the current element |
| mem_rvalid | input | 1 | Read data valid, returned in request order |
| mem_rdata | input | DW | Read data word |
| wr_en | output | 1 | Vector register write strobe |
| wr_idx | output | IW | Element index of the write |
| wr_data | output | DW | Element value |
| done | output | 1 | One-cycle completion pulse |
| cycles | output | CW | Length of the last load in cycles |

## Verification
The bench builds the block with its defaults: eight banks, a busy time of six, 64-element vectors, and a behavioural memory with a 12-cycle return latency. With six busy cycles and eight banks, a unit or odd stride can stream without stalls. Strides of 2 and 4 leave only four or two banks active, which is fewer than the busy time, so they produce periodic stalls. Strides that are multiples of eight give full serialisation onto a single bank. All three timing regimes can therefore be checked against fixed cycle counts as well as against an in-order greedy bank model computed in the bench.

// File: rtl/vld_pkg.sv
package vld_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_DRAIN = 2'd2,
        ST_DONE  = 2'd3
    } vld_state_t;
endpackage

// File: rtl/vld_bank_tracker.sv
module vld_bank_tracker #(
    parameter int NB   = 8,
    parameter int BUSY = 6,
    localparam int BW  = $clog2(NB),
    localparam int TW  = $clog2(BUSY + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [BW-1:0] bank_sel,
    input  logic          take,
    output logic          sel_free
);
    logic [NB-1:0] free_vec;

    genvar b;
    generate
        for (b = 0; b < NB; b++) begin : g_bank
            logic [TW-1:0] wait_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    wait_q <= '0;
                else if (take && bank_sel == BW'(b))
                    wait_q <= TW'(BUSY - 1);
                else if (wait_q != '0)
                    wait_q <= wait_q - TW'(1);
            end
            assign free_vec[b] = (wait_q == '0);
        end
    endgenerate

    assign sel_free = free_vec[bank_sel];
endmodule

// File: rtl/vld_addr_gen.sv
module vld_addr_gen #(
    parameter int AW = 16,
    parameter int LW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] stride,
    input  logic          advance,
    output logic [AW-1:0] addr,
    output logic [LW-1:0] issued
);
    logic [AW-1:0] step_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr   <= '0;
            step_q <= '0;
            issued <= '0;
        end else if (load) begin
            addr   <= base;
            step_q <= stride;
            issued <= '0;
        end else if (advance) begin
            addr   <= addr + step_q;
            issued <= issued + LW'(1);
        end
    end
endmodule

// File: rtl/vld_strided_load.sv
module vld_strided_load
    import vld_pkg::*;
#(
    parameter int AW    = 16,
    parameter int DW    = 32,
    parameter int NB    = 8,
    parameter int BUSY  = 6,
    parameter int MAXVL = 64,
    parameter int CW    = 16,
    parameter int LW    = $clog2(MAXVL + 1),
    parameter int IW    = $clog2(MAXVL)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] stride,
    input  logic [LW-1:0] vlen,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    input  logic          mem_rvalid,
    input  logic [DW-1:0] mem_rdata,
    output logic          wr_en,
    output logic [IW-1:0] wr_idx,
    output logic [DW-1:0] wr_data,
    output logic          done,
    output logic [CW-1:0] cycles
);
    localparam int BW = $clog2(NB);

    vld_state_t    state_q, state_d;
    logic [LW-1:0] vlen_q, vlen_eff, issued, ret_q;
    logic          tgt_free, launch;

    assign vlen_eff = (vlen > LW'(MAXVL)) ? LW'(MAXVL) : vlen;
    assign launch   = (state_q == ST_IDLE) && start;

    vld_addr_gen #(.AW(AW), .LW(LW)) u_agen (
        .clk(clk), .rst_n(rst_n), .load(launch), .base(base), .stride(stride),
        .advance(mem_req), .addr(mem_addr), .issued(issued)
    );

    vld_bank_tracker #(.NB(NB), .BUSY(BUSY)) u_banks (
        .clk(clk), .rst_n(rst_n), .bank_sel(mem_addr[BW-1:0]),
        .take(mem_req), .sel_free(tgt_free)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = (vlen_eff == '0) ? ST_DONE : ST_ISSUE;
            ST_ISSUE: if (mem_req && issued == vlen_q - LW'(1)) state_d = ST_DRAIN;
            ST_DRAIN: if (wr_en && ret_q == vlen_q - LW'(1)) state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        mem_req = (state_q == ST_ISSUE) && tgt_free;
        wr_en   = mem_rvalid && (state_q == ST_ISSUE || state_q == ST_DRAIN);
        wr_idx  = ret_q[IW-1:0];
        wr_data = mem_rdata;
        done    = (state_q == ST_DONE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vlen_q <= '0;
            ret_q  <= '0;
            cycles <= '0;
        end else if (launch) begin
            vlen_q <= vlen_eff;
            ret_q  <= '0;
            cycles <= '0;
        end else begin
            if (wr_en) ret_q <= ret_q + LW'(1);
            if (state_q == ST_ISSUE || state_q == ST_DRAIN) cycles <= cycles + CW'(1);
        end
    end
endmodule

// File: rtl/vld_strided_load_chk.sv
module vld_strided_load_chk
    import vld_pkg::*;
#(
    parameter int AW = 16,
    parameter int NB = 8,
    parameter int LW = 7,
    parameter int IW = 6,
    localparam int BW = $clog2(NB)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic [LW-1:0] vlen,
    input logic [AW-1:0] base,
    input logic          mem_req,
    input logic [AW-1:0] mem_addr,
    input logic          wr_en,
    input logic [IW-1:0] wr_idx,
    input logic          done,
    input vld_state_t    state_q
);
    // R3
    bank_gap1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && $past(mem_req) |-> mem_addr[BW-1:0] != $past(mem_addr[BW-1:0]));
    // R3
    bank_gap2_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && $past(mem_req, 2) |-> mem_addr[BW-1:0] != $past(mem_addr[BW-1:0], 2));
    // R2
    first_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start && state_q == ST_IDLE |=> mem_addr == $past(base));
    // R5
    wr_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && $past(wr_en) |-> wr_idx == $past(wr_idx) + IW'(1));
    // R9
    zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start && state_q == ST_IDLE && vlen == '0 |=> done && !mem_req && !wr_en);
    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

bind vld_strided_load vld_strided_load_chk #(.AW(AW), .NB(NB), .LW(LW), .IW(IW)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .vlen(vlen), .base(base),
    .mem_req(mem_req), .mem_addr(mem_addr), .wr_en(wr_en), .wr_idx(wr_idx),
    .done(done), .state_q(state_q)
);

// File: tb/tb_vld_strided_load.sv
module tb_vld_strided_load;
    localparam int AW = 16, DW = 32, NB = 8, BUSY = 6, MAXVL = 64, CW = 16;
    localparam int LW = $clog2(MAXVL + 1), IW = $clog2(MAXVL), LAT = 12;

    logic clk = 0, rst_n = 0, start = 0;
    logic [AW-1:0] base = 0, stride = 0;
    logic [LW-1:0] vlen = 0;
    logic mem_req, mem_rvalid, wr_en, done;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_rdata, wr_data;
    logic [IW-1:0] wr_idx;
    logic [CW-1:0] cycles;

    int n_tests = 0, n_fail = 0;
    int tcyc = 0;
    int last_wr_cyc = 0, done_cyc = -1, req_cnt = 0;
    int bank_last [NB];
    int exp_idx_q[$];
    logic [DW-1:0] exp_dat_q[$];
    logic [AW-1:0] exp_adr_q[$];

    always #10 clk = ~clk;

    vld_strided_load #(.AW(AW), .DW(DW), .NB(NB), .BUSY(BUSY), .MAXVL(MAXVL), .CW(CW)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .base(base), .stride(stride), .vlen(vlen),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .done(done), .cycles(cycles)
    );

    function automatic logic [DW-1:0] mem_fn(logic [AW-1:0] a);
        return {a ^ 16'h5A3C, ~a};
    endfunction

    // behavioural memory: fixed return latency
    logic          pv [LAT];
    logic [AW-1:0] pa [LAT];
    initial for (int k = 0; k < LAT; k++) begin pv[k] = 0; pa[k] = 0; end
    always @(posedge clk) begin
        tcyc <= tcyc + 1;
        pv[0] <= mem_req;
        pa[0] <= mem_addr;
        for (int k = 1; k < LAT; k++) begin pv[k] <= pv[k-1]; pa[k] <= pa[k-1]; end
    end
    assign mem_rvalid = pv[LAT-1];
    assign mem_rdata  = mem_fn(pa[LAT-1]);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // monitor
    initial for (int b = 0; b < NB; b++) bank_last[b] = -1000;
    always @(negedge clk) begin
        if (rst_n && mem_req) begin
            int b;
            b = int'(mem_addr) % NB;
            req_cnt++;
            chk(tcyc - bank_last[b] >= BUSY, "R3 bank reuse gap", tcyc - bank_last[b], BUSY);
            bank_last[b] = tcyc;
            if (exp_adr_q.size() == 0) chk(0, "R2 unexpected request", int'(mem_addr), -1);
            else begin
                logic [AW-1:0] ea;
                ea = exp_adr_q.pop_front();
                chk(mem_addr == ea, "R2 request address", int'(mem_addr), int'(ea));
            end
        end
        if (rst_n && wr_en) begin
            last_wr_cyc = tcyc;
            if (exp_idx_q.size() == 0) chk(0, "R5 unexpected write", int'(wr_idx), -1);
            else begin
                int ei;
                logic [DW-1:0] ed;
                ei = exp_idx_q.pop_front();
                ed = exp_dat_q.pop_front();
                chk(int'(wr_idx) == ei, "R5 write index", int'(wr_idx), ei);
                chk(wr_data == ed, "R5 write data", int'(wr_data), int'(ed));
            end
        end
        if (rst_n && done) done_cyc = tcyc;
    end

    // driver: pushes expectations, runs one load, checks its timing
    task automatic run_load(input logic [AW-1:0] b, input logic [AW-1:0] s, input int len,
                            input int fixed_cnt, input string req);
        int n, t, last, exp_cnt, start_cyc, w, free_at [NB];
        logic [AW-1:0] a;
        n = (len > MAXVL) ? MAXVL : len;
        for (int k = 0; k < NB; k++) free_at[k] = 0;
        t = 0; last = 0;
        for (int i = 0; i < n; i++) begin
            a = b + AW'(i) * s;
            exp_adr_q.push_back(a);
            exp_idx_q.push_back(i);
            exp_dat_q.push_back(mem_fn(a));
            if (free_at[int'(a) % NB] > t) t = free_at[int'(a) % NB];
            free_at[int'(a) % NB] = t + BUSY;
            last = t;
            t++;
        end
        exp_cnt = (n == 0) ? 0 : last + LAT + 1;
        req_cnt = 0; done_cyc = -1;
        base = b; stride = s; vlen = LW'(len); start = 1;
        start_cyc = tcyc;
        @(negedge clk);
        start = 0;
        w = 0;
        while (done_cyc < 0 && w < 2000) begin
            if (!done) @(negedge clk);
            if (done) done_cyc = tcyc;
            w++;
        end
        chk(w < 2000, "watchdog", w, 0);
        chk(int'(cycles) == exp_cnt, req, int'(cycles), exp_cnt);
        if (fixed_cnt >= 0) chk(int'(cycles) == fixed_cnt, req, int'(cycles), fixed_cnt);
        chk(req_cnt == n, "R2 request count", req_cnt, n);
        chk(exp_idx_q.size() == 0, "R5 missing writes", exp_idx_q.size(), 0);
        if (n == 0) chk(done_cyc == start_cyc + 1, "R9 done timing", done_cyc, start_cyc + 1);
        else        chk(done_cyc == last_wr_cyc + 1, "R10 done after last write", done_cyc, last_wr_cyc + 1);
        if (n > 0 && s == 1) chk(exp_cnt == n + LAT, "R4 back-to-back issue", exp_cnt, n + LAT);
        repeat (3) @(negedge clk);
        chk(!done, "R10 done single cycle", int'(done), 0);
        chk(int'(cycles) == exp_cnt, "R10 count held", int'(cycles), exp_cnt);
        exp_adr_q.delete(); exp_idx_q.delete(); exp_dat_q.delete();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!mem_req && !wr_en && !done, "R1 outputs quiet in reset", int'({mem_req, wr_en, done}), 0);
        chk(cycles == 0, "R1 count reset", int'(cycles), 0);
        rst_n = 1;
        repeat (2) @(negedge clk);
        run_load(16'h0100, 16'd1,  64, 76,  "R6 stride 1 count");
        run_load(16'h0040, 16'd32, 64, 391, "R7 stride 32 count");
        run_load(16'h0003, 16'd9,  64, 76,  "R8 stride 9 count");
        run_load(16'h0000, 16'd2,  64, 106, "R8 stride 2 count");
        run_load(16'h0011, 16'd4,  64, 200, "R8 stride 4 count");
        run_load(16'h0200, 16'd0,  3,  25,  "R8 stride 0 count");
        run_load(16'h0500, 16'd8,  0,  0,   "R9 zero length count");
        run_load(16'hFFFE, 16'd3,  5,  -1,  "R2 wrapping address count");
        run_load(16'h0020, 16'd1,  100, 76, "R11 clamped length count");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(20 * 200000);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule